// File: doc/BRIEF.md
# Slice-Paced Word DMA Channel

This block is a single DMA channel that copies 32-bit words from an incrementing memory address into one fixed peripheral FIFO address. Software loads a source address, a destination address, a word count and a slice length, then arms the channel. Both the count and the slice length are programmed as the wanted number minus one. Each word appears on a simple valid/ready transfer port that the surrounding fabric turns into a memory read and a FIFO write.

Work proceeds in slices. In request-paced mode a slice starts only when the peripheral raises its request line. In free-running mode slices follow one another without waiting. A slice is issued as a run of word beats, and its final beat is marked. When the last programmed word has moved, a sticky completion flag is set, and it drives the interrupt output unless its mask bit is set. Software can read back the live source address and the number of words still outstanding at any time. A run-enable input stands in for the channel clock: holding it low freezes every register, and raising it again resumes the transfer where it stopped.

Top module: `dma_slice_channel`

## Requirements
- R1: After reset every register reads zero (register index 0 to 7), `irq` is low and `xfer_valid` is low.
- R2: Enabling the channel with count register (index 4) holding C moves exactly C+1 words. The first beat carries the source register (index 2) value, and each later beat's source is 4 higher than the previous one. Every beat carries the destination register (index 3) value unchanged.
- R3: With slice register (index 5) holding S, every slice except possibly the last has S+1 beats. The last slice holds only the words still remaining. `xfer_last` is high on exactly the final beat of each slice, and no slice exceeds S+1 beats.
- R4: With control bit 1 set (request-paced), no slice starts while `per_req` is low. The channel offers no beat while it waits.
- R5: In request-paced mode a request that is high during a slice and gone before the slice ends is remembered, and it starts the next slice once the current one finishes.
- R6: With control bit 1 clear (free-running), slices start without any request until the count is used up.
- R7: Status register (index 1) bit 1 (done) is set by the final word. Status bit 0 (active) is set when a slice starts and is cleared by the final word.
- R8: `irq` is high exactly when done is set and status bit 8 (done mask) is clear. Setting the mask hides a pending done and clearing it shows the done again.
- R9: Writing zero to the status register clears done and active, and `irq` falls after that write.
- R10: Writing a control value with bit 0 clear stops the channel: `xfer_valid` is low from the cycle after the write, and no further words move.
- R11: Writing a control value with bit 0 set reloads the live source from the source register and the outstanding count from count+1, and it clears active.
- R12: Register index 6 reads the next source address, and index 7 reads the number of words still outstanding.
- R13: While `run_en` is low no beat is offered and no register changes. After `run_en` returns high the transfer completes with the full programmed word count.
- R14: While `xfer_valid` is high and `xfer_ready` is low, `xfer_src` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Channel run enable; low freezes all state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| per_req | input | 1 | Peripheral request for the next slice |
| xfer_valid | output | 1 | A word beat is offered |
| xfer_ready | input | 1 | Fabric accepts the offered beat |
| xfer_src | output | 32 | Memory source address of the beat |
| xfer_dst | output | 32 | Fixed FIFO destination address |
| xfer_last | output | 1 | Final beat of the current slice |
| irq | output | 1 | Unmasked completion interrupt |

## Verification
A fault in the live source or remaining-count registers shows on the very next accepted beat: `xfer_src` breaks its step of 4, or the beat total differs from count+1 when `irq` rises. A wrong slice-length counter shows within one slice as a misplaced `xfer_last` or an oversized run of beats. A lost pending request shows as a transfer that stalls with words outstanding, which the index 7 readback reports. Flag faults appear on `irq` one cycle after the final word or after a status write.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int WORD_BYTES = 4;

    // register indices on the 3-bit register port
    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_STAT    = 3'd1,
        RA_SRC     = 3'd2,
        RA_DST     = 3'd3,
        RA_CNT     = 3'd4,
        RA_SLICE   = 3'd5,
        RA_CUR_SRC = 3'd6,
        RA_CUR_CNT = 3'd7
    } reg_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_HW_BIT   = 1;
    localparam int STAT_ACT_BIT  = 0;
    localparam int STAT_DONE_BIT = 1;
    localparam int STAT_MASK_BIT = 8;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_e;

    // events from the sequencer to the flag logic
    typedef struct packed {
        logic slice_start;
        logic last_word;
    } seq_evt_t;

endpackage

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              ch_en,
    input  logic              hw_trig,
    input  logic              reload,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  logic [SLICE_W-1:0] cfg_slice,
    input  logic              per_req,
    input  logic              xfer_ready,
    output logic              xfer_valid,
    output logic [ADDR_W-1:0] xfer_src,
    output logic              xfer_last,
    output logic [ADDR_W-1:0] cur_src,
    output logic [CNT_W:0]    cur_rem,
    output seq_evt_t          evt
);

    localparam int REM_W  = CNT_W + 1;
    localparam int BEAT_W = SLICE_W + 1;

    seq_state_e          st;
    logic [ADDR_W-1:0]   src_q;
    logic [REM_W-1:0]    rem_q;
    logic [BEAT_W-1:0]   beats_q;
    logic                pend_q;

    logic [BEAT_W-1:0]   slice_words;
    logic [BEAT_W-1:0]   first_len;
    logic                trig;
    logic                start;
    logic                beat;

    assign slice_words = BEAT_W'(cfg_slice) + BEAT_W'(1);
    assign first_len   = (rem_q < REM_W'(slice_words)) ? BEAT_W'(rem_q) : slice_words;
    assign trig        = hw_trig ? (per_req | pend_q) : 1'b1;
    assign start       = run_en && !reload && ch_en && (st == SEQ_IDLE)
                         && (rem_q != '0) && trig;

    assign xfer_valid  = (st == SEQ_BURST) && ch_en && run_en;
    assign beat        = xfer_valid && xfer_ready;
    assign xfer_src    = src_q;
    assign xfer_last   = (beats_q == BEAT_W'(1));
    assign cur_src     = src_q;
    assign cur_rem     = rem_q;

    assign evt.slice_start = start;
    assign evt.last_word   = beat && !reload && (rem_q == REM_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SEQ_IDLE;
            src_q   <= '0;
            rem_q   <= '0;
            beats_q <= '0;
            pend_q  <= 1'b0;
        end else if (run_en) begin
            if (reload) begin
                src_q   <= cfg_src;
                rem_q   <= {1'b0, cfg_cnt} + REM_W'(1);
                st      <= SEQ_IDLE;
                beats_q <= '0;
                pend_q  <= 1'b0;
            end else if (!ch_en) begin
                st     <= SEQ_IDLE;
                pend_q <= 1'b0;
            end else begin
                unique case (st)
                    SEQ_IDLE: begin
                        if (start) begin
                            st      <= SEQ_BURST;
                            beats_q <= first_len;
                            pend_q  <= 1'b0;
                        end
                    end
                    SEQ_BURST: begin
                        if (per_req) pend_q <= 1'b1;
                        if (xfer_ready) begin
                            src_q   <= src_q + ADDR_W'(WORD_BYTES);
                            rem_q   <= rem_q - REM_W'(1);
                            beats_q <= beats_q - BEAT_W'(1);
                            if (beats_q == BEAT_W'(1)) st <= SEQ_IDLE;
                        end
                    end
                    default: st <= SEQ_IDLE;
                endcase
            end
        end
    end

    // R3
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_BURST) |-> (beats_q != '0 && REM_W'(beats_q) <= rem_q));

    // R2
    word_step_chk: assert property (@(posedge clk) disable iff (rst)
        (beat && !reload) |=> (rem_q == $past(rem_q) - REM_W'(1)
                               && src_q == $past(src_q) + ADDR_W'(WORD_BYTES)));

    // R4
    req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && ch_en && hw_trig && st == SEQ_IDLE && !per_req && !pend_q && !reload)
        |=> (st == SEQ_IDLE));

    // R13
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> ($stable(src_q) && $stable(rem_q) && $stable(beats_q)));

    // R14
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_ready && !reload) |=> $stable(xfer_src));

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int SLICE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [ADDR_W-1:0]  cur_src,
    input  logic [CNT_W:0]     cur_rem,
    input  seq_evt_t           evt,
    output logic [ADDR_W-1:0]  cfg_src,
    output logic [ADDR_W-1:0]  cfg_dst,
    output logic [CNT_W-1:0]   cfg_cnt,
    output logic [SLICE_W-1:0] cfg_slice,
    output logic               ch_en,
    output logic               hw_trig,
    output logic               reload,
    output logic               irq
);

    logic act_q, done_q, mask_q;
    logic act_n, done_n;
    logic stat_wr;
    reg_addr_e ra;

    assign ra      = reg_addr_e'(reg_addr);
    assign stat_wr = run_en && reg_we && (ra == RA_STAT);
    assign reload  = run_en && reg_we && (ra == RA_CTRL) && reg_wdata[CTRL_EN_BIT];
    assign irq     = done_q && !mask_q;

    always_comb begin
        act_n  = act_q;
        done_n = done_q;
        if (stat_wr) begin
            act_n  = act_q  & reg_wdata[STAT_ACT_BIT];
            done_n = done_q & reg_wdata[STAT_DONE_BIT];
        end
        if (reload)          act_n = 1'b0;
        if (evt.slice_start) act_n = 1'b1;
        if (evt.last_word) begin
            act_n  = 1'b0;
            done_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_src   <= '0;
            cfg_dst   <= '0;
            cfg_cnt   <= '0;
            cfg_slice <= '0;
            ch_en     <= 1'b0;
            hw_trig   <= 1'b0;
            act_q     <= 1'b0;
            done_q    <= 1'b0;
            mask_q    <= 1'b0;
        end else if (run_en) begin
            act_q  <= act_n;
            done_q <= done_n;
            if (reg_we) begin
                unique case (ra)
                    RA_CTRL: begin
                        ch_en   <= reg_wdata[CTRL_EN_BIT];
                        hw_trig <= reg_wdata[CTRL_HW_BIT];
                    end
                    RA_STAT:  mask_q    <= reg_wdata[STAT_MASK_BIT];
                    RA_SRC:   cfg_src   <= reg_wdata[ADDR_W-1:0];
                    RA_DST:   cfg_dst   <= reg_wdata[ADDR_W-1:0];
                    RA_CNT:   cfg_cnt   <= reg_wdata[CNT_W-1:0];
                    RA_SLICE: cfg_slice <= reg_wdata[SLICE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (ra)
            RA_CTRL: begin
                reg_rdata[CTRL_EN_BIT] = ch_en;
                reg_rdata[CTRL_HW_BIT] = hw_trig;
            end
            RA_STAT: begin
                reg_rdata[STAT_ACT_BIT]  = act_q;
                reg_rdata[STAT_DONE_BIT] = done_q;
                reg_rdata[STAT_MASK_BIT] = mask_q;
            end
            RA_SRC:     reg_rdata[ADDR_W-1:0]  = cfg_src;
            RA_DST:     reg_rdata[ADDR_W-1:0]  = cfg_dst;
            RA_CNT:     reg_rdata[CNT_W-1:0]   = cfg_cnt;
            RA_SLICE:   reg_rdata[SLICE_W-1:0] = cfg_slice;
            RA_CUR_SRC: reg_rdata[ADDR_W-1:0]  = cur_src;
            RA_CUR_CNT: reg_rdata[CNT_W:0]     = cur_rem;
            default: ;
        endcase
    end

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && evt.last_word && !mask_q && !(reg_we && ra == RA_STAT)) |=> irq);

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && reg_wdata[STAT_DONE_BIT:STAT_ACT_BIT] == 2'b00
         && !evt.last_word && !evt.slice_start) |=> (!irq && !act_q));

    // R7
    done_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && evt.last_word) |=> (done_q && !act_q));

endmodule

// File: rtl/dma_slice_channel.sv
module dma_slice_channel
    import dma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              per_req,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic              xfer_last,
    output logic              irq
);

    logic [ADDR_W-1:0]  cfg_src, cfg_dst, cur_src;
    logic [CNT_W-1:0]   cfg_cnt;
    logic [SLICE_W-1:0] cfg_slice;
    logic [CNT_W:0]     cur_rem;
    logic               ch_en, hw_trig, reload;
    seq_evt_t           evt;

    assign xfer_dst = cfg_dst;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cur_src   (cur_src),
        .cur_rem   (cur_rem),
        .evt       (evt),
        .cfg_src   (cfg_src),
        .cfg_dst   (cfg_dst),
        .cfg_cnt   (cfg_cnt),
        .cfg_slice (cfg_slice),
        .ch_en     (ch_en),
        .hw_trig   (hw_trig),
        .reload    (reload),
        .irq       (irq)
    );

    dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .ch_en      (ch_en),
        .hw_trig    (hw_trig),
        .reload     (reload),
        .cfg_src    (cfg_src),
        .cfg_cnt    (cfg_cnt),
        .cfg_slice  (cfg_slice),
        .per_req    (per_req),
        .xfer_ready (xfer_ready),
        .xfer_valid (xfer_valid),
        .xfer_src   (xfer_src),
        .xfer_last  (xfer_last),
        .cur_src    (cur_src),
        .cur_rem    (cur_rem),
        .evt        (evt)
    );

    // R10
    stop_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && reg_we && reg_addr == 3'd0 && !reg_wdata[0]) |=> !xfer_valid);

endmodule

// File: tb/tb_dma_slice_channel.sv
module tb_dma_slice_channel;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_SRC = 3'd2, A_DST = 3'd3,
                           A_CNT = 3'd4, A_SLICE = 3'd5, A_CSRC = 3'd6, A_CCNT = 3'd7;

    // {src, count-1, slice-1, request-paced, stall pattern}
    localparam logic [57:0] VECS [NVEC] = '{
        {32'h0000_1000, 16'd7,  8'd7,  1'b1, 1'b0},
        {32'h0000_2000, 16'd9,  8'd3,  1'b1, 1'b0},
        {32'h0000_3000, 16'd0,  8'd7,  1'b1, 1'b1},
        {32'h0000_4000, 16'd20, 8'd0,  1'b0, 1'b0},
        {32'h0000_5000, 16'd15, 8'd7,  1'b0, 1'b1},
        {32'h0000_6000, 16'd2,  8'd15, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        xfer_valid;
    logic        xfer_ready = 1'b1;
    logic [31:0] xfer_src, xfer_dst;
    logic        xfer_last;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int beats, lasts, src_err, dst_err, slice_err, stall_err, run_len, slice_lim;
    int cyc = 0;
    logic [31:0] exp_src, exp_dst, held_addr;
    logic held = 1'b0;
    logic stall_mode = 1'b0;

    dma_slice_channel dut (
        .clk(clk), .rst(rst), .run_en(run_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_src(xfer_src),
        .xfer_dst(xfer_dst), .xfer_last(xfer_last), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        xfer_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // beat monitor: samples between edges what the next edge will accept
    always @(negedge clk) begin
        #2;
        if (!rst && xfer_valid) begin
            if (held && xfer_src !== held_addr) stall_err = stall_err + 1;
            if (xfer_ready) begin
                held = 1'b0;
                beats = beats + 1;
                if (xfer_src !== exp_src) src_err = src_err + 1;
                if (xfer_dst !== exp_dst) dst_err = dst_err + 1;
                exp_src = exp_src + 32'd4;
                run_len = run_len + 1;
                if (run_len > slice_lim) slice_err = slice_err + 1;
                if (xfer_last) begin
                    lasts = lasts + 1;
                    run_len = 0;
                end
            end else begin
                held = 1'b1;
                held_addr = xfer_src;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic arm_monitor(input logic [31:0] s, input logic [31:0] dd, input int lim);
        exp_src = s; exp_dst = dd; slice_lim = lim;
        beats = 0; lasts = 0; src_err = 0; dst_err = 0; slice_err = 0;
        stall_err = 0; run_len = 0; held = 1'b0;
    endtask

    task automatic wait_irq(input int lim);
        int k = 0;
        while (!irq && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        logic [31:0] d, d2;
        logic [57:0] v;
        logic [31:0] vsrc;
        int vcnt, vsl, words, slices, b0;
        logic vhw;

        arm_monitor(32'h0, 32'h0, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d);
            chk($sformatf("R1 reset reg %0d", a), d, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
        chk("R1 reset xfer_valid", {31'b0, xfer_valid}, 32'h0);

        // table of full transfers
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            vsrc = v[57:26]; vcnt = int'(v[25:10]); vsl = int'(v[9:2]);
            vhw = v[1]; stall_mode = v[0];
            words = vcnt + 1;
            slices = (words + vsl) / (vsl + 1);
            wr(A_STAT, 32'h0);
            wr(A_SRC, vsrc);
            wr(A_DST, 32'hF000_0040 + i);
            wr(A_CNT, vcnt);
            wr(A_SLICE, vsl);
            arm_monitor(vsrc, 32'hF000_0040 + i, vsl + 1);
            per_req = vhw;
            wr(A_CTRL, {30'b0, vhw, 1'b1});
            wait_irq(5000);
            per_req = 1'b0;
            repeat (3) @(negedge clk);
            stall_mode = 1'b0;
            chk(vhw ? "R2 word count" : "R6 free-run word count", beats, words);
            chk("R2 source sequence errors", src_err, 0);
            chk("R2 fixed destination errors", dst_err, 0);
            chk("R3 last-beat markers", lasts, slices);
            chk("R3 oversized slices", slice_err, 0);
            chk("R14 address held under stall", stall_err, 0);
            chk("R8 irq on done", {31'b0, irq}, 32'h1);
            rd(A_STAT, d);
            chk("R7 status after completion", d, 32'h2);
            rd(A_CCNT, d);
            chk("R12 outstanding count at end", d, 32'h0);
            rd(A_CSRC, d);
            chk("R12 live source at end", d, vsrc + 32'(4 * words));
        end

        // R4: request-paced, no request, nothing moves
        wr(A_STAT, 32'h0);
        wr(A_SRC, 32'h0000_8000);
        wr(A_CNT, 32'd7);
        wr(A_SLICE, 32'd3);
        arm_monitor(32'h0000_8000, 32'hF000_0045, 4);
        wr(A_CTRL, 32'h3);
        repeat (20) @(negedge clk);
        chk("R4 no beats without request", beats, 0);
        rd(A_CCNT, d);
        chk("R11 reload of outstanding count", d, 32'd8);
        rd(A_STAT, d);
        chk("R4 status idle without request", d, 32'h0);

        // R5: one pulse starts a slice, a pulse during that slice is held
        @(negedge clk); per_req = 1'b1;
        @(negedge clk); per_req = 1'b0;
        @(negedge clk); per_req = 1'b1;
        @(negedge clk); per_req = 1'b0;
        repeat (30) @(negedge clk);
        chk("R5 held request runs second slice", beats, 8);
        chk("R3 two slices marked", lasts, 2);

        // R8 mask, R9 clear
        chk("R8 irq before mask", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h102);
        chk("R8 irq hidden by mask", {31'b0, irq}, 32'h0);
        rd(A_STAT, d);
        chk("R8 status with mask", d, 32'h102);
        wr(A_STAT, 32'h002);
        chk("R8 irq after unmask", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h0);
        chk("R9 irq after status clear", {31'b0, irq}, 32'h0);
        rd(A_STAT, d);
        chk("R9 status cleared", d, 32'h0);

        // R13: freeze mid-transfer
        wr(A_SRC, 32'h0000_9000);
        wr(A_CNT, 32'd15);
        wr(A_SLICE, 32'd7);
        arm_monitor(32'h0000_9000, 32'hF000_0045, 8);
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        #3 b0 = beats;
        rd(A_CCNT, d);
        repeat (10) @(negedge clk);
        rd(A_CCNT, d2);
        chk("R13 no beats while frozen", beats, b0);
        chk("R13 count stable while frozen", d2, d);
        chk("R13 valid low while frozen", {31'b0, xfer_valid}, 32'h0);
        run_en = 1'b1;
        wait_irq(500);
        repeat (2) @(negedge clk);
        chk("R13 full count after resume", beats, 16);
        chk("R13 source sequence after resume", src_err, 0);

        // R10: stop mid-transfer
        wr(A_STAT, 32'h0);
        wr(A_SRC, 32'h0000_A000);
        wr(A_CNT, 32'd31);
        arm_monitor(32'h0000_A000, 32'hF000_0045, 8);
        wr(A_CTRL, 32'h1);
        repeat (5) @(negedge clk);
        wr(A_CTRL, 32'h0);
        chk("R10 valid low after stop", {31'b0, xfer_valid}, 32'h0);
        b0 = beats;
        repeat (10) @(negedge clk);
        chk("R10 no beats after stop", beats, b0);
        rd(A_CCNT, d);
        chk("R12 outstanding after stop", d, 32'(32 - b0));
        rd(A_STAT, d);
        chk("R7 active after stop", d & 32'h1, 32'h1);

        // R11: re-enable reloads and clears active
        arm_monitor(32'h0000_A000, 32'hF000_0045, 8);
        wr(A_CTRL, 32'h3);
        rd(A_CCNT, d);
        chk("R11 count reloaded", d, 32'd32);
        rd(A_CSRC, d);
        chk("R11 source reloaded", d, 32'h0000_A000);
        rd(A_STAT, d);
        chk("R11 active cleared", d & 32'h1, 32'h0);
        per_req = 1'b1;
        wait_irq(1000);
        per_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 full transfer after reload", beats, 32);
        chk("R11 source sequence after reload", src_err, 0);

        summary();
        $finish;
    end

endmodule